// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block stores a stream of trace words in a circular on-chip RAM while capture is enabled. Each accepted word goes to the slot named by a write pointer, and the pointer wraps modulo the depth. When the pointer first wraps, a sticky Full flag is raised. From then on the write pointer names the oldest valid word. While Full is clear, the write pointer equals the number of valid words.

A trigger input marks the event of interest. After the trigger word is stored, a programmable countdown sets how many further words are kept. When the countdown runs out, acquisition completes and storing stops. One cycle later a formatter-empty flag reports that no store is still in flight. Software reaches nine 32-bit registers through a simple address/strobe port. Through them it reads the identity and geometry of the buffer, sets the pointers and the countdown, starts and stops capture, and drains the RAM one word per data-register read.

Top module: `trace_ring_buf`

## Requirements
- R1: After reset all four status bits, both pointers, the trigger countdown and the control register read as zero.
- R2: Address 0 returns the constant 0x7B0C0A51. Address 1 returns DEPTH and address 2 returns WIDTH.
- R3: While control bit 0 is set and acquisition is not complete, each cycle with `cap_valid` high stores `cap_data` at the write pointer and advances the pointer modulo DEPTH. With control bit 0 clear, nothing is stored and the write pointer holds.
- R4: Status bit 0 (Full) sets when a word is stored at slot DEPTH-1 and stays set until it is cleared. The write pointer then names the oldest word.
- R5: Status bit 1 (Triggered) sets when a word is stored with `cap_trig` high.
- R6: Address 7 holds the countdown. Each word stored after the trigger word decrements it. Once it reads zero with Triggered set, status bit 2 (acquisition complete) sets on the next edge and no further words are stored.
- R7: Status bit 3 (formatter empty) rises exactly one cycle after status bit 2.
- R8: A strobed read of address 4 returns the word at the read pointer and advances the read pointer modulo DEPTH. The read pointer at address 5 is writable.
- R9: The write pointer at address 6 is writable and reads back what was written.
- R10: Address 8 stores bit 0 (enable) and bit 1 (demultiplexed port mode) and reads them back. A write with bit 0 set clears Full, Triggered and acquisition complete. Writing 0 stops capture.
- R11: Writes to addresses 0 through 4 have no effect on any register or on the read pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | Trace word present this cycle |
| cap_data | input | WIDTH | Trace word |
| cap_trig | input | 1 | Trigger mark for this word |
| cfg_addr | input | 4 | Register address 0..8 |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (advances the read pointer at address 4) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr`, combinational |

## Verification
The assertions take for granted that register strobes and trace input are applied while reset is low, and that `cfg_addr` names one of the nine registers whenever a strobe is high. The stimulus drives one register access or one trace word per cycle, always on the falling edge. It only issues addresses 0 through 8. It reads the RAM only at slots it has written since reset, so every expected value comes from a bench-side copy of the stored words.

// File: rtl/trace_ring_pkg.sv
package trace_ring_pkg;

    localparam logic [31:0] TRB_IDENT = 32'h7B0C_0A51;

    typedef enum logic [3:0] {
        RA_IDENT  = 4'd0,
        RA_DEPTH  = 4'd1,
        RA_WIDTH  = 4'd2,
        RA_STATUS = 4'd3,
        RA_DATA   = 4'd4,
        RA_RPTR   = 4'd5,
        RA_WPTR   = 4'd6,
        RA_TCOUNT = 4'd7,
        RA_CTRL   = 4'd8
    } trb_addr_e;

    // status bit order is visible to software: {fmt_empty, acq_done, triggered, full}
    typedef struct packed {
        logic fmt_empty;
        logic acq_done;
        logic triggered;
        logic full;
    } trb_status_t;

    typedef struct packed {
        logic demux;
        logic enable;
    } trb_ctrl_t;

    typedef struct packed {
        logic wr_wptr;
        logic wr_rptr;
        logic wr_tcount;
        logic wr_ctrl;
        logic rd_data;
    } trb_cmd_t;

    function automatic logic addr_is(input logic [3:0] a, input trb_addr_e r);
        return a == r;
    endfunction

endpackage

// File: rtl/trb_ram.sv
module trb_ram #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 24,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_word,
    input  logic [AW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_word
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_word;
        end
    end

    assign rd_word = cells[rd_idx];
endmodule

// File: rtl/trb_regmap.sv
module trb_regmap
    import trace_ring_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIDTH = 24,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic [3:0]       addr,
    input  logic             wr,
    input  logic             rd,
    input  trb_status_t      status,
    input  trb_ctrl_t        ctrl,
    input  logic [AW-1:0]    rptr,
    input  logic [AW-1:0]    wptr,
    input  logic [31:0]      tcount,
    input  logic [WIDTH-1:0] ram_word,
    output trb_cmd_t         cmd,
    output logic [31:0]      rdata
);
    always_comb begin
        cmd.wr_wptr   = wr && addr_is(addr, RA_WPTR);
        cmd.wr_rptr   = wr && addr_is(addr, RA_RPTR);
        cmd.wr_tcount = wr && addr_is(addr, RA_TCOUNT);
        cmd.wr_ctrl   = wr && addr_is(addr, RA_CTRL);
        cmd.rd_data   = rd && addr_is(addr, RA_DATA);
    end

    always_comb begin
        unique case (addr)
            RA_IDENT:  rdata = TRB_IDENT;
            RA_DEPTH:  rdata = 32'(DEPTH);
            RA_WIDTH:  rdata = 32'(WIDTH);
            RA_STATUS: rdata = 32'(status);
            RA_DATA:   rdata = 32'(ram_word);
            RA_RPTR:   rdata = 32'(rptr);
            RA_WPTR:   rdata = 32'(wptr);
            RA_TCOUNT: rdata = tcount;
            RA_CTRL:   rdata = 32'(ctrl);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/trb_capture.sv
module trb_capture
    import trace_ring_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIDTH = 24,
    localparam int AW = $clog2(DEPTH),
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_valid,
    input  logic             cap_trig,
    input  logic [WIDTH-1:0] cap_data,
    input  trb_cmd_t         cmd,
    input  logic [31:0]      wdata,
    output trb_status_t      status,
    output trb_ctrl_t        ctrl,
    output logic [AW-1:0]    wptr,
    output logic [31:0]      tcount,
    output logic             st_en,
    output logic [AW-1:0]    st_idx,
    output logic [WIDTH-1:0] st_word
);
    logic count_spent;
    logic restart;

    always_comb begin
        count_spent = status.triggered && (tcount == '0);
        restart     = cmd.wr_ctrl && wdata[0];
        st_en       = ctrl.enable && cap_valid && !status.acq_done && !count_spent;
        st_idx      = wptr;
        st_word     = cap_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            ctrl   <= '0;
            wptr   <= '0;
            tcount <= '0;
        end else begin
            if (cmd.wr_ctrl) begin
                ctrl.enable <= wdata[0];
                ctrl.demux  <= wdata[1];
            end

            status.fmt_empty <= status.acq_done;

            if (restart) begin
                status.full      <= 1'b0;
                status.triggered <= 1'b0;
                status.acq_done  <= 1'b0;
            end else begin
                if (st_en && wptr == LAST) begin
                    status.full <= 1'b1;
                end
                if (st_en && cap_trig) begin
                    status.triggered <= 1'b1;
                end
                if (ctrl.enable && count_spent) begin
                    status.acq_done <= 1'b1;
                end
            end

            if (cmd.wr_wptr) begin
                wptr <= wdata[AW-1:0];
            end else if (st_en) begin
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            end

            if (cmd.wr_tcount) begin
                tcount <= wdata;
            end else if (st_en && status.triggered) begin
                tcount <= tcount - 1'b1;
            end
        end
    end
endmodule

// File: rtl/trace_ring_buf.sv
module trace_ring_buf
    import trace_ring_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_valid,
    input  logic [WIDTH-1:0] cap_data,
    input  logic             cap_trig,
    input  logic [3:0]       cfg_addr,
    input  logic             cfg_wr,
    input  logic             cfg_rd,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    trb_cmd_t         cmd;
    trb_status_t      status_q;
    trb_ctrl_t        ctrl_q;
    logic [AW-1:0]    wptr_q;
    logic [AW-1:0]    rptr_q;
    logic [31:0]      tcount_q;
    logic             st_en;
    logic [AW-1:0]    st_idx;
    logic [WIDTH-1:0] st_word;
    logic [WIDTH-1:0] ram_word;

    trb_regmap #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_map (
        .addr(cfg_addr), .wr(cfg_wr), .rd(cfg_rd),
        .status(status_q), .ctrl(ctrl_q), .rptr(rptr_q), .wptr(wptr_q),
        .tcount(tcount_q), .ram_word(ram_word), .cmd(cmd), .rdata(cfg_rdata)
    );

    trb_capture #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_cap (
        .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_trig(cap_trig),
        .cap_data(cap_data), .cmd(cmd), .wdata(cfg_wdata),
        .status(status_q), .ctrl(ctrl_q), .wptr(wptr_q), .tcount(tcount_q),
        .st_en(st_en), .st_idx(st_idx), .st_word(st_word)
    );

    trb_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
        .clk(clk), .wr_en(st_en), .wr_idx(st_idx), .wr_word(st_word),
        .rd_idx(rptr_q), .rd_word(ram_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr_q <= '0;
        end else if (cmd.wr_rptr) begin
            rptr_q <= cfg_wdata[AW-1:0];
        end else if (cmd.rd_data) begin
            rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/trace_ring_buf_chk.sv
module trace_ring_buf_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          cap_valid,
    input logic [3:0]    cfg_addr,
    input logic          cfg_wr,
    input logic          cfg_rd,
    input logic          ctl_set,
    input logic          full,
    input logic          trig,
    input logic          done,
    input logic          empty,
    input logic [AW-1:0] wptr,
    input logic [AW-1:0] rptr
);
    // R3
    wptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cap_valid && !(cfg_wr && cfg_addr == 4'd6)) |=> $stable(wptr));

    // R8
    rptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(cfg_rd && cfg_addr == 4'd4) && !(cfg_wr && cfg_addr == 4'd5)) |=> $stable(rptr));

    // R4
    full_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !ctl_set) |=> full);

    // R6
    done_needs_trig_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> trig);

    // R6
    done_freezes_wptr_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !(cfg_wr && cfg_addr == 4'd6)) |=> $stable(wptr));

    // R7
    empty_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(empty) |-> $past(done));
endmodule

bind trace_ring_buf trace_ring_buf_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .cap_valid(cap_valid), .cfg_addr(cfg_addr),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .ctl_set(cfg_wr && cfg_addr == 4'd8 && cfg_wdata[0]),
    .full(status_q.full), .trig(status_q.triggered),
    .done(status_q.acq_done), .empty(status_q.fmt_empty),
    .wptr(wptr_q), .rptr(rptr_q)
);

// File: tb/trace_ring_buf_test.sv
module trace_ring_buf_test;
    localparam int DEPTH = 8;
    localparam int WIDTH = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cap_valid = 1'b0;
    logic [WIDTH-1:0] cap_data = '0;
    logic             cap_trig = 1'b0;
    logic [3:0]       cfg_addr = '0;
    logic             cfg_wr = 1'b0;
    logic             cfg_rd = 1'b0;
    logic [31:0]      cfg_wdata = '0;
    logic [31:0]      cfg_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    trace_ring_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
        .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_data(cap_data),
        .cap_trig(cap_trig), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // every task starts just after a falling edge and consumes one rising edge
    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        cfg_addr = a; cfg_rd = 1'b1;
        #2 d = cfg_rdata;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic push(input logic [WIDTH-1:0] w, input logic t);
        cap_valid = 1'b1; cap_data = w; cap_trig = t;
        @(negedge clk);
        cap_valid = 1'b0; cap_trig = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd_reg(a, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset;
        expect_reg("R1 status", 4'd3, 32'h0);
        expect_reg("R1 rptr", 4'd5, 32'h0);
        expect_reg("R1 wptr", 4'd6, 32'h0);
        expect_reg("R1 tcount", 4'd7, 32'h0);
        expect_reg("R1 ctrl", 4'd8, 32'h0);
    endtask

    task automatic t_ident;
        expect_reg("R2 ident", 4'd0, 32'h7B0C_0A51);
        expect_reg("R2 depth", 4'd1, DEPTH);
        expect_reg("R2 width", 4'd2, WIDTH);
    endtask

    task automatic t_readonly;
        for (int a = 0; a < 5; a++) wr_reg(4'(a), 32'hFFFF_FFFF);
        expect_reg("R11 ident", 4'd0, 32'h7B0C_0A51);
        expect_reg("R11 depth", 4'd1, DEPTH);
        expect_reg("R11 width", 4'd2, WIDTH);
        expect_reg("R11 status", 4'd3, 32'h0);
        expect_reg("R11 rptr", 4'd5, 32'h0);
    endtask

    task automatic t_disabled;
        push(16'h1111, 1'b0);
        push(16'h2222, 1'b1);
        expect_reg("R3 disabled wptr", 4'd6, 32'h0);
        expect_reg("R3 disabled status", 4'd3, 32'h0);
    endtask

    task automatic t_basic;
        wr_reg(4'd6, 32'd6);
        expect_reg("R9 wptr write", 4'd6, 32'd6);
        wr_reg(4'd6, 32'd0);
        expect_reg("R9 wptr zero", 4'd6, 32'd0);
        wr_reg(4'd7, 32'd100);
        wr_reg(4'd8, 32'd1);
        for (int i = 0; i < 3; i++) push(16'hA0 + 16'(i), 1'b0);
        expect_reg("R3 wptr count", 4'd6, 32'd3);
        expect_reg("R4 no full yet", 4'd3, 32'h0);
        wr_reg(4'd5, 32'd0);
        for (int i = 0; i < 3; i++) expect_reg("R8 data", 4'd4, 32'hA0 + i);
        expect_reg("R8 rptr advance", 4'd5, 32'd3);
    endtask

    task automatic t_wrap;
        for (int i = 0; i < 6; i++) push(16'hB0 + 16'(i), 1'b0);
        expect_reg("R4 full set", 4'd3, 32'h1);
        expect_reg("R4 wptr oldest", 4'd6, 32'd1);
        wr_reg(4'd5, 32'd7);
        expect_reg("R8 data slot7", 4'd4, 32'hB4);
        expect_reg("R8 data wrapped", 4'd4, 32'hB5);
        expect_reg("R8 rptr wrap", 4'd5, 32'd1);
        expect_reg("R4 full sticky", 4'd3, 32'h1);
    endtask

    task automatic t_trigger;
        wr_reg(4'd8, 32'd1);
        expect_reg("R10 full cleared", 4'd3, 32'h0);
        wr_reg(4'd6, 32'd0);
        wr_reg(4'd7, 32'd2);
        push(16'hC0, 1'b0);
        push(16'hC1, 1'b0);
        expect_reg("R5 not yet", 4'd3, 32'h0);
        push(16'hC2, 1'b1);
        expect_reg("R6 tcount held", 4'd7, 32'd2);
        push(16'hC3, 1'b0);
        push(16'hC4, 1'b0);
        expect_reg("R5 triggered", 4'd3, 32'h2);
        expect_reg("R6 done", 4'd3, 32'h6);
        expect_reg("R7 empty", 4'd3, 32'hE);
        push(16'hC5, 1'b0);
        expect_reg("R6 wptr stop", 4'd6, 32'd5);
        expect_reg("R6 tcount zero", 4'd7, 32'd0);
        wr_reg(4'd5, 32'd4);
        expect_reg("R6 last kept", 4'd4, 32'hC4);
        expect_reg("R6 not stored", 4'd4, 32'hB2);
    endtask

    task automatic t_control;
        wr_reg(4'd8, 32'd3);
        expect_reg("R10 clear flags", 4'd3, 32'h8);
        expect_reg("R7 empty follows", 4'd3, 32'h0);
        expect_reg("R10 ctrl readback", 4'd8, 32'd3);
        wr_reg(4'd8, 32'd0);
        push(16'hD0, 1'b0);
        expect_reg("R10 stopped", 4'd6, 32'd5);
        expect_reg("R10 ctrl zero", 4'd8, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ident();
        t_readonly();
        t_disabled();
        t_basic();
        t_wrap();
        t_trigger();
        t_control();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule